// File: doc/BRIEF.md
# Vector element step sequencer

This block sequences the element positions of vector instructions in a scalar pipeline that has been extended to handle vectors. It holds a maximum vector length (MVL), a current vector length (VL), a source step counter and a destination step counter. Length-setting requests come from a decoded issue interface. A request carries three flag bits (vf, vs, ms), a register value and an immediate, and it either rewrites the lengths, reads VL back, or advances the step counters. A separate strobe announces each vector instruction. A per-element predicate mask decides which positions may run.

The block works in one of two persistent modes. In horizontal mode an issued vector instruction walks every enabled position below VL, one per cycle and in ascending order, and the program-counter advance strobe comes with the final position. In vertical-first mode every issued instruction runs exactly one position: the one the step counters hold. The advance strobe comes at once and the counters stay where they are. An explicit step request then moves both counters to the next enabled position. When no enabled position is left, the counters wrap to 0 and a one-cycle end-of-vector flag is raised, which an outer branch loop can test.

Top module: `vstep_seq`

## Requirements
- R1: After reset, MVL, VL and both step counters are 0 and the mode is horizontal. All output strobes are low, a VL read returns 0, and an issued vector instruction gives only the PC-advance strobe.
- R2: A request with ms=1 loads MVL with min(value, 64). A request with vs=1 loads VL with min(value, MVL), where MVL is the value after this request. The value is the immediate when op_use_imm=1 and the register value otherwise. One cycle after any request other than a step, vl_rsp_valid is high and vl_rsp carries the resulting VL.
- R3: A request with ms=1 and vs=1 loads both lengths from the one selected value, so VL becomes min(value, 64).
- R4: A request with ms=1 and vs=0 leaves VL as it was unless VL exceeds the new MVL. In that case VL drops to the new MVL.
- R5: A request with vs=0, ms=0 and vf=0 reads VL. VL and MVL are unchanged, and the mode becomes horizontal.
- R6: In horizontal mode, an issued instruction gives one element_valid strobe per cycle for each index i < VL whose mask bit i is 1. The strobes start the cycle after the issue and run in ascending order. pc_adv is high in the cycle of the last strobe only, and mask bits at or above VL are ignored.
- R7: In horizontal mode, if no index below VL is enabled, pc_adv is high one cycle after the issue and no element_valid strobe occurs.
- R8: A length-writing request with vf=1 selects vertical-first mode. In that mode, an issued instruction gives one cycle later a single element_valid (high only if VL > 0) at the current step index, with pc_adv high in the same cycle. The steps are unchanged.
- R9: A request with vf=1, vs=0 and ms=0 is a step. Both counters move to the smallest index greater than the current step, below VL, whose mask bit is 1. The mode is not changed.
- R10: If a step finds no such index, both counters become 0 and end_of_vec is high for exactly the one cycle after the step request.
- R11: Any request with vs=1 or ms=1 resets both step counters to 0.
- R12: A vertical-first issue and a step request in the same cycle run the element at the step index that held before the step. The next issue sees the advanced index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Length-setting request present |
| op_vf | input | 1 | Request flag: vertical-first select / step |
| op_vs | input | 1 | Request flag: load VL |
| op_ms | input | 1 | Request flag: load MVL |
| op_use_imm | input | 1 | 1 selects the immediate as length value, 0 the register value |
| op_reg_val | input | DATAW (16) | Register operand |
| op_imm | input | DATAW (16) | Immediate operand |
| vec_issue | input | 1 | A vector instruction is issued |
| pred_mask | input | MAX_LEN (64) | Per-element enable mask, bit i for index i |
| elem_valid | output | 1 | An element runs this cycle |
| elem_src_idx | output | 6 | Source element index |
| elem_dst_idx | output | 6 | Destination element index |
| pc_adv | output | 1 | Instruction complete, PC may advance |
| end_of_vec | output | 1 | Step wrapped to 0 |
| vl_rsp_valid | output | 1 | vl_rsp is valid |
| vl_rsp | output | 7 | VL after the last non-step request |

## Verification
A vertical-first instruction issue and an explicit step request can fall in the same cycle. The first reads the step counters and the second rewrites them. The bench drives both on one edge, with the counters at index 0 and the mask enabling index 2 next. It then requires the reported element to be index 0 and the following issue to report index 2. The wrap case is also provoked: the step request at the last enabled position must raise end_of_vec for exactly one cycle, and the next issue must see index 0.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    typedef enum logic {
        MODE_HORIZ = 1'b0,
        MODE_VERT  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        OPK_NONE  = 2'd0,
        OPK_READ  = 2'd1,
        OPK_WRITE = 2'd2,
        OPK_STEP  = 2'd3
    } opk_e;

    // Classify a length-setting request from its flag bits.
    function automatic opk_e decode_op(logic v, logic vf, logic vs, logic ms);
        if (!v)
            return OPK_NONE;
        if (vs || ms)
            return OPK_WRITE;
        if (vf)
            return OPK_STEP;
        return OPK_READ;
    endfunction

endpackage

// File: rtl/vstep_find.sv
// Lowest enabled element index relative to a start point, below a limit.
module vstep_find #(
    parameter  int N  = 64,
    localparam int IW = $clog2(N),
    localparam int LW = IW + 1
) (
    input  logic [N-1:0]  mask,
    input  logic [IW-1:0] start,
    input  logic          incl,
    input  logic [LW-1:0] limit,
    output logic          found,
    output logic [IW-1:0] idx
);

    logic [N-1:0] qual;

    for (genvar i = 0; i < N; i++) begin : g_qual
        assign qual[i] = mask[i] && (LW'(i) < limit) &&
                         (incl ? (IW'(i) >= start) : (IW'(i) > start));
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (qual[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/vstep_len_ctl.sv
// Holds MVL and VL; applies clamping on writes.
module vstep_len_ctl #(
    parameter  int MAX_LEN = 64,
    parameter  int DATAW   = 16,
    localparam int LW      = $clog2(MAX_LEN) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             ld_mvl,
    input  logic             ld_vl,
    input  logic [DATAW-1:0] val,
    output logic [LW-1:0]    mvl,
    output logic [LW-1:0]    vl,
    output logic [LW-1:0]    next_vl
);

    typedef struct packed {
        logic [LW-1:0] mvl;
        logic [LW-1:0] vl;
    } len_t;

    len_t len_d, len_q;

    function automatic logic [LW-1:0] clamp_len(logic [DATAW-1:0] v);
        if (32'(v) > MAX_LEN)
            return LW'(MAX_LEN);
        return LW'(v);
    endfunction

    always_comb begin
        logic [LW-1:0] cv;
        len_d = len_q;
        cv    = clamp_len(val);
        if (wr_en) begin
            if (ld_mvl)
                len_d.mvl = cv;
            if (ld_vl)
                len_d.vl = (cv > len_d.mvl) ? len_d.mvl : cv;
            else if (len_q.vl > len_d.mvl)
                len_d.vl = len_d.mvl;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            len_q <= '0;
        else
            len_q <= len_d;
    end

    assign mvl     = len_q.mvl;
    assign vl      = len_q.vl;
    assign next_vl = len_d.vl;

endmodule

// File: rtl/vstep_step_ctl.sv
// Source and destination step counters for vertical-first operation.
module vstep_step_ctl #(
    parameter  int N  = 64,
    localparam int IW = $clog2(N),
    localparam int LW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          adv,
    input  logic [N-1:0]  mask,
    input  logic [LW-1:0] vl,
    output logic [IW-1:0] src,
    output logic [IW-1:0] dst,
    output logic          wrap
);

    localparam int LANES = 2;

    logic [LANES-1:0]          lane_wrap;
    logic [LANES-1:0][IW-1:0]  lane_val;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IW-1:0] step_d, step_q;
        logic          nx_found;
        logic [IW-1:0] nx_idx;
        logic          wrap_d;

        vstep_find #(.N(N)) u_find (
            .mask  (mask),
            .start (step_q),
            .incl  (1'b0),
            .limit (vl),
            .found (nx_found),
            .idx   (nx_idx)
        );

        always_comb begin
            step_d = step_q;
            wrap_d = 1'b0;
            if (clear) begin
                step_d = '0;
            end else if (adv) begin
                if (nx_found) begin
                    step_d = nx_idx;
                end else begin
                    step_d = '0;
                    wrap_d = 1'b1;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)
                step_q <= '0;
            else
                step_q <= step_d;
        end

        assign lane_val[k]  = step_q;
        assign lane_wrap[k] = wrap_d;
    end

    assign src  = lane_val[0];
    assign dst  = lane_val[1];
    assign wrap = |lane_wrap;

endmodule

// File: rtl/vstep_horiz.sv
// Horizontal element walker: one enabled index per cycle, lookahead for the last one.
module vstep_horiz #(
    parameter  int N  = 64,
    localparam int IW = $clog2(N),
    localparam int LW = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [N-1:0]  mask,
    input  logic [LW-1:0] vl,
    output logic          busy,
    output logic          emit,
    output logic [IW-1:0] idx,
    output logic          last
);

    typedef struct packed {
        logic          busy;
        logic [IW-1:0] cur;
    } walk_t;

    walk_t w_d, w_q;

    logic          a_found, b_found;
    logic [IW-1:0] a_idx, b_idx;
    logic          active;

    vstep_find #(.N(N)) u_cur (
        .mask  (mask),
        .start (w_q.busy ? w_q.cur : '0),
        .incl  (1'b1),
        .limit (vl),
        .found (a_found),
        .idx   (a_idx)
    );

    vstep_find #(.N(N)) u_next (
        .mask  (mask),
        .start (a_idx),
        .incl  (1'b0),
        .limit (vl),
        .found (b_found),
        .idx   (b_idx)
    );

    always_comb begin
        active   = start || w_q.busy;
        w_d      = w_q;
        w_d.busy = active && a_found && b_found;
        if (active)
            w_d.cur = b_idx;
        emit = active && a_found;
        idx  = a_idx;
        last = active && (!a_found || !b_found);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            w_q <= '0;
        else
            w_q <= w_d;
    end

    assign busy = w_q.busy;

endmodule

// File: rtl/vstep_seq.sv
module vstep_seq
    import vstep_pkg::*;
#(
    parameter  int MAX_LEN = 64,
    parameter  int DATAW   = 16,
    localparam int IW      = $clog2(MAX_LEN),
    localparam int LW      = IW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic             op_vf,
    input  logic             op_vs,
    input  logic             op_ms,
    input  logic             op_use_imm,
    input  logic [DATAW-1:0] op_reg_val,
    input  logic [DATAW-1:0] op_imm,
    input  logic             vec_issue,
    input  logic [MAX_LEN-1:0] pred_mask,
    output logic             elem_valid,
    output logic [IW-1:0]    elem_src_idx,
    output logic [IW-1:0]    elem_dst_idx,
    output logic             pc_adv,
    output logic             end_of_vec,
    output logic             vl_rsp_valid,
    output logic [LW-1:0]    vl_rsp
);

    typedef struct packed {
        mode_e         mode;
        logic          ev;
        logic [IW-1:0] src;
        logic [IW-1:0] dst;
        logic          pc;
        logic          eov;
        logic          rv;
        logic [LW-1:0] rvl;
    } seq_t;

    seq_t st_d, st_q;

    opk_e             opk;
    logic [DATAW-1:0] len_val;
    logic [LW-1:0]    len_mvl, len_vl, len_next;
    logic [IW-1:0]    step_src, step_dst;
    logic             step_wrap;
    logic             h_busy, h_emit, h_last;
    logic [IW-1:0]    h_idx;
    logic             h_start, v_issue;
    logic             mode_vert;

    assign opk     = decode_op(op_valid, op_vf, op_vs, op_ms);
    assign len_val = op_use_imm ? op_imm : op_reg_val;
    assign h_start = vec_issue && (st_q.mode == MODE_HORIZ) && !h_busy;
    assign v_issue = vec_issue && (st_q.mode == MODE_VERT);
    assign mode_vert = (st_q.mode == MODE_VERT);

    vstep_len_ctl #(.MAX_LEN(MAX_LEN), .DATAW(DATAW)) u_len (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (opk == OPK_WRITE),
        .ld_mvl  (op_ms),
        .ld_vl   (op_vs),
        .val     (len_val),
        .mvl     (len_mvl),
        .vl      (len_vl),
        .next_vl (len_next)
    );

    vstep_step_ctl #(.N(MAX_LEN)) u_step (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (opk == OPK_WRITE),
        .adv   (opk == OPK_STEP),
        .mask  (pred_mask),
        .vl    (len_vl),
        .src   (step_src),
        .dst   (step_dst),
        .wrap  (step_wrap)
    );

    vstep_horiz #(.N(MAX_LEN)) u_horiz (
        .clk   (clk),
        .rst_n (rst_n),
        .start (h_start),
        .mask  (pred_mask),
        .vl    (len_vl),
        .busy  (h_busy),
        .emit  (h_emit),
        .idx   (h_idx),
        .last  (h_last)
    );

    always_comb begin
        st_d = st_q;
        if (opk == OPK_WRITE || opk == OPK_READ)
            st_d.mode = op_vf ? MODE_VERT : MODE_HORIZ;
        if (v_issue) begin
            st_d.ev  = (len_vl != '0);
            st_d.src = step_src;
            st_d.dst = step_dst;
            st_d.pc  = 1'b1;
        end else begin
            st_d.ev  = h_emit;
            st_d.src = h_idx;
            st_d.dst = h_idx;
            st_d.pc  = h_last;
        end
        st_d.eov = step_wrap;
        st_d.rv  = (opk == OPK_WRITE || opk == OPK_READ);
        if (st_d.rv)
            st_d.rvl = len_next;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign elem_valid   = st_q.ev;
    assign elem_src_idx = st_q.src;
    assign elem_dst_idx = st_q.dst;
    assign pc_adv       = st_q.pc;
    assign end_of_vec   = st_q.eov;
    assign vl_rsp_valid = st_q.rv;
    assign vl_rsp       = st_q.rvl;

endmodule

// File: rtl/vstep_seq_chk.sv
module vstep_seq_chk #(
    parameter  int MAX_LEN = 64,
    localparam int IW      = $clog2(MAX_LEN),
    localparam int LW      = IW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          elem_valid,
    input logic [IW-1:0] elem_dst_idx,
    input logic          pc_adv,
    input logic          end_of_vec,
    input logic          vl_rsp_valid,
    input logic [LW-1:0] vl_rsp,
    input logic [LW-1:0] len_mvl,
    input logic [LW-1:0] len_vl,
    input logic [IW-1:0] step_src,
    input logic [IW-1:0] step_dst,
    input logic          mode_vert
);

    assert_vl_le_mvl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        len_vl <= len_mvl);

    assert_mvl_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        len_mvl <= LW'(MAX_LEN));

    assert_rsp_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vl_rsp_valid |-> vl_rsp <= len_mvl);

    assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        elem_valid |-> LW'(elem_dst_idx) < $past(len_vl));

    assert_vert_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (elem_valid && !pc_adv) |-> !$past(mode_vert));

    assert_lanes_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        step_src == step_dst);

    assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        end_of_vec |-> (step_dst == '0 && step_src == '0));

endmodule

bind vstep_seq vstep_seq_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .elem_valid   (elem_valid),
    .elem_dst_idx (elem_dst_idx),
    .pc_adv       (pc_adv),
    .end_of_vec   (end_of_vec),
    .vl_rsp_valid (vl_rsp_valid),
    .vl_rsp       (vl_rsp),
    .len_mvl      (len_mvl),
    .len_vl       (len_vl),
    .step_src     (step_src),
    .step_dst     (step_dst),
    .mode_vert    (mode_vert)
);

// File: tb/sim_vstep_seq.sv
`timescale 1ns/1ps
module sim_vstep_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0, op_vf = 1'b0, op_vs = 1'b0, op_ms = 1'b0, op_use_imm = 1'b0;
    logic [15:0] op_reg_val = '0, op_imm = '0;
    logic        vec_issue = 1'b0;
    logic [63:0] pred_mask = '0;
    logic        elem_valid, pc_adv, end_of_vec, vl_rsp_valid;
    logic [5:0]  elem_src_idx, elem_dst_idx;
    logic [6:0]  vl_rsp;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    vstep_seq u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_vf(op_vf), .op_vs(op_vs),
        .op_ms(op_ms), .op_use_imm(op_use_imm), .op_reg_val(op_reg_val), .op_imm(op_imm),
        .vec_issue(vec_issue), .pred_mask(pred_mask), .elem_valid(elem_valid),
        .elem_src_idx(elem_src_idx), .elem_dst_idx(elem_dst_idx), .pc_adv(pc_adv),
        .end_of_vec(end_of_vec), .vl_rsp_valid(vl_rsp_valid), .vl_rsp(vl_rsp)
    );

    typedef struct packed {
        logic        vf, vs, ms, imm_sel;
        logic [15:0] regv;
        logic [15:0] immv;
        logic [6:0]  exp_vl;
        logic [3:0]  req;
    } tv_t;

    localparam int NTV = 10;
    localparam tv_t TV [NTV] = '{
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd0,  16'd10,  7'd10, 4'd3}, // R3 both from one value
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'd20, 16'd0,   7'd10, 4'd2}, // R2 VL clamped by MVL
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'd0,  16'd4,   7'd4,  4'd2}, // R2 immediate VL
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd0,  16'd2,   7'd2,  4'd4}, // R4 VL drops to MVL
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd9,  16'd0,   7'd2,  4'd5}, // R5 read
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd0,  16'd100, 7'd64, 4'd3}, // R3 capped at 64
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'd0,  16'd0,   7'd0,  4'd2}, // R2 VL zero
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'd0,  16'd64,  7'd64, 4'd2}, // R2 VL full
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd0,  16'd30,  7'd30, 4'd4}, // R4 shrink MVL
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd0,  16'd0,   7'd30, 4'd5}  // R5 read
    };

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the next negedge with results visible.
    task automatic do_op(logic vf, logic vs, logic ms, logic isel, logic [15:0] rv, logic [15:0] iv);
        op_valid = 1'b1; op_vf = vf; op_vs = vs; op_ms = ms; op_use_imm = isel;
        op_reg_val = rv; op_imm = iv;
        @(negedge clk);
        op_valid = 1'b0; op_vf = 1'b0; op_vs = 1'b0; op_ms = 1'b0;
    endtask

    task automatic set_len(logic vf, int n, string tag);
        do_op(vf, 1'b1, 1'b1, 1'b1, 16'd0, 16'(n));
        chk({tag, " rsp"}, int'(vl_rsp), n);
    endtask

    task automatic vissue(int exp_v, int exp_idx, string tag);
        vec_issue = 1'b1;
        @(negedge clk);
        vec_issue = 1'b0;
        chk({tag, " elem_valid"}, int'(elem_valid), exp_v);
        chk({tag, " pc_adv"}, int'(pc_adv), 1);
        if (exp_v != 0) begin
            chk({tag, " dst"}, int'(elem_dst_idx), exp_idx);
            chk({tag, " src"}, int'(elem_src_idx), exp_idx);
        end
    endtask

    task automatic step_op(int exp_eov, string tag);
        do_op(1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
        chk({tag, " end_of_vec"}, int'(end_of_vec), exp_eov);
        chk({tag, " no rsp"}, int'(vl_rsp_valid), 0);
    endtask

    task automatic run_h(logic [63:0] m, int vl, string tag);
        int exp_idx [64];
        int cnt = 0;
        pred_mask = m;
        for (int i = 0; i < vl; i++)
            if (m[i]) begin exp_idx[cnt] = i; cnt++; end
        vec_issue = 1'b1;
        @(negedge clk);
        vec_issue = 1'b0;
        if (cnt == 0) begin
            chk({tag, " empty elem_valid"}, int'(elem_valid), 0);
            chk({tag, " empty pc_adv"}, int'(pc_adv), 1);
        end else begin
            for (int k = 0; k < cnt; k++) begin
                chk({tag, " elem_valid"}, int'(elem_valid), 1);
                chk({tag, " idx"}, int'(elem_dst_idx), exp_idx[k]);
                chk({tag, " pc_adv"}, int'(pc_adv), (k == cnt - 1) ? 1 : 0);
                if (k != cnt - 1) @(negedge clk);
            end
        end
        @(negedge clk);
        chk({tag, " quiet after"}, int'(elem_valid) + int'(pc_adv), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 elem_valid", int'(elem_valid), 0);
        chk("R1 pc_adv", int'(pc_adv), 0);
        chk("R1 end_of_vec", int'(end_of_vec), 0);
        chk("R1 rsp_valid", int'(vl_rsp_valid), 0);
        run_h(64'hFFFF, 0, "R1 issue after reset");
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
        chk("R1 read valid", int'(vl_rsp_valid), 1);
        chk("R1 read VL", int'(vl_rsp), 0);

        // length table (R2 R3 R4 R5)
        for (int t = 0; t < NTV; t++) begin
            do_op(TV[t].vf, TV[t].vs, TV[t].ms, TV[t].imm_sel, TV[t].regv, TV[t].immv);
            n_run++;
            if (!vl_rsp_valid || vl_rsp != TV[t].exp_vl) begin
                n_fail++;
                $display("FAIL R%0d vector %0d actual=%0d/%0d expected=1/%0d",
                         TV[t].req, t, vl_rsp_valid, vl_rsp, TV[t].exp_vl);
            end
        end

        // horizontal walks (R6 R7)
        set_len(1'b0, 8, "R6 setup");
        run_h(64'h2A6, 8, "R6 sparse");
        run_h(64'h0, 8, "R7 no bits");
        run_h(64'h300, 8, "R7 bits above VL");
        set_len(1'b0, 3, "R6 setup3");
        run_h(64'hFFFF_FFFF_FFFF_FFFF, 3, "R6 dense");

        // vertical-first (R8 R9 R10 R11 R12)
        pred_mask = 64'b101100;
        set_len(1'b1, 6, "R8 setup");
        vissue(1, 0, "R8 first");
        vissue(1, 0, "R8 steps frozen");
        step_op(0, "R9 step to 2");
        vissue(1, 2, "R9 at 2");
        step_op(0, "R9 step to 3");
        vissue(1, 3, "R9 at 3");
        step_op(0, "R9 step to 5");
        vissue(1, 5, "R9 at 5");
        step_op(1, "R10 wrap");
        vec_issue = 1'b1;
        @(negedge clk);
        vec_issue = 1'b0;
        chk("R10 pulse one cycle", int'(end_of_vec), 0);
        chk("R10 back at 0", int'(elem_dst_idx), 0);

        // R12 issue and step in one cycle
        vec_issue = 1'b1; op_valid = 1'b1; op_vf = 1'b1;
        @(negedge clk);
        vec_issue = 1'b0; op_valid = 1'b0; op_vf = 1'b0;
        chk("R12 old index", int'(elem_dst_idx), 0);
        chk("R12 elem_valid", int'(elem_valid), 1);
        vissue(1, 2, "R12 advanced index");

        // R11 length write clears steps
        step_op(0, "R11 step to 3");
        set_len(1'b1, 6, "R11 rewrite");
        vissue(1, 0, "R11 cleared");

        // R8 R10 with VL of zero
        set_len(1'b1, 0, "R8 zero setup");
        vissue(0, 0, "R8 zero VL");
        step_op(1, "R10 zero VL wrap");

        // R9 step keeps mode; R5 read returns to horizontal
        set_len(1'b1, 4, "R9 setup");
        step_op(0, "R9 step in vert");
        vissue(1, 2, "R9 mode kept");
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 16'd0);
        chk("R5 read VL", int'(vl_rsp), 4);
        run_h(64'hF, 4, "R5 horizontal again");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule